// File: doc/BRIEF.md
# Timing Source Priority Selector

This block picks the reference clock for a system from a set of candidate timing sources. There are up to sixteen clocks recovered from incoming E1 lines plus two local oscillators, a main one and a standby one. Each candidate comes with a health flag. A source must stay healthy for a programmable number of qualification ticks before it counts as usable. The block then drives a select index toward the best usable source. The index is meant to steer an external clock multiplexer. Alongside it the block gives a valid flag and a one-cycle pulse each time the selection changes.

There are two operating modes.

- **Table mode:** software loads a priority table of up to eight entries. Each entry names one candidate. The highest-ranked usable entry wins. Switching is revertive: when a better source becomes usable again, the block returns to it.
- **Paired mode:** used when two boards work as a primary/standby pair. The table is ignored and a fixed four-step order is used instead. The order is the primary board's line 0, the partner board's line 0, the main oscillator, then the standby oscillator.

The control is a two-state machine.

- **FREE:** no usable source. The output rests on the main oscillator and the valid flag is low.
- **LOCKED:** a usable source is driving the reference.

The transitions are:

- **ACQUIRE** (FREE to LOCKED): a usable source appears.
- **HANDOVER** (LOCKED to LOCKED): a different source now ranks best.
- **LOSE** (LOCKED to FREE): no usable source remains.
- **HOLD:** the state and the selection stay as they are.

Top module: `tsel_top`

## Requirements
- R1: Candidate indices are fixed as follows: 0 to N_LINE-1 are the line clocks (`line_ok` bit i), N_LINE is the main oscillator (`osc_ok[0]`) and N_LINE+1 is the standby oscillator (`osc_ok[1]`). `ref_sel` never holds any other value.
- R2: In table mode, entry k occupies `prio_tab[6k+5:6k]`. Bit 5 of the entry is its enable and bits 4:0 are its source index. Entry 0 ranks highest, and the first enabled entry whose source is usable is selected.
- R3: A source becomes usable only when both of the following hold:
  - its health flag has been high without a break through `qual_limit` clock cycles in which `qual_tick` was high;
  - (a break restarts the count, and cycles without `qual_tick` do not count.)

  With `qual_limit` = 0 a healthy source is usable at once. `ref_sel` moves on the clock edge after the source becomes usable.
- R4: When the health flag of the active source falls, `ref_sel` moves on the next clock edge. It moves to the best remaining usable source, or to the fallback of R6 if none remains.
- R5: Switching is revertive. Once a higher-ranked source is usable again, the selector returns to it.
- R6: When no candidate is usable, `ref_sel` equals N_LINE (the main oscillator) and `ref_valid` is low. While a selected source drives the output, `ref_valid` is high.
- R7: `ref_switch` is high for exactly the one cycle in which `ref_sel` shows a new value, and low otherwise.
- R8: The search skips entries whose enable bit is 0 and entries whose index is above N_LINE+1, even if the named source is healthy.
- R9: With `paired_mode` high, the table is ignored and the search order is 0, 1, N_LINE, N_LINE+1. Index 1 carries the partner board's line 0.
- R10: In paired mode no line index other than 0 and 1 is ever selected.
- R11: After reset, `ref_sel` = N_LINE, `ref_valid` = 0 and `ref_switch` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qual_tick | input | 1 | Qualification time-base strobe |
| line_ok | input | N_LINE | Health flags of the line clocks |
| osc_ok | input | 2 | Health of the main (bit 0) and standby (bit 1) oscillators |
| paired_mode | input | 1 | 1 = fixed four-step paired order, 0 = priority table |
| qual_limit | input | QW | Qualification ticks required |
| prio_tab | input | N_PRIO*6 | Priority table, entry 0 in the low bits |
| ref_sel | output | SW | Index of the active reference source |
| ref_valid | output | 1 | A usable source is selected |
| ref_switch | output | 1 | One-cycle pulse when `ref_sel` changes |

## Verification
The bench targets the edges of qualification timing.

- **Off by one in the count:** the bench checks that the source is still rejected one tick short of the limit. A counter that is off by one would switch a cycle early.
- **Ticks ignored:** the bench checks that time without ticks does not qualify a source. A design that counted raw clocks would switch anyway.
- **Table decode:** disabled entries and out-of-range indices are loaded alongside healthy sources. A decoder that ignores the enable bit would pick the disabled one.
- **Revert to a better source:** after a failover the bench checks the return to the higher-ranked source. A non-revertive design would stay put.
- **Paired mode:** the full four-step chain is walked while a table entry points at a healthy non-port-0 line. A selector that still read the table would jump there.
- **Loss of every source:** the bench checks that the output lands on the main oscillator with the valid flag low and one switch pulse. A design that held the stale index would keep valid high.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    // Two-state selector: FREE (nothing usable, parked on main oscillator)
    // and LOCKED (a usable source drives the reference).
    typedef enum logic [0:0] {
        ST_FREE   = 1'b0,
        ST_LOCKED = 1'b1
    } sel_state_t;

    // Width of one priority table entry: enable bit + 5-bit index.
    localparam int ENT_W = 6;
    localparam int IDX_W = 5;

endpackage

// File: rtl/tsel_qualifier.sv
module tsel_qualifier #(
    parameter int QW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ok,
    input  logic [QW-1:0] limit,
    output logic          qual
);

    logic [QW-1:0] cnt;

    // Count ticks of uninterrupted health, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!ok) begin
            cnt <= '0;
        end else if (tick && (cnt < limit)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qual = ok && (cnt >= limit);

endmodule

// File: rtl/tsel_picker.sv
module tsel_picker
    import tsel_pkg::*;
#(
    parameter int N_LINE = 16,
    parameter int N_PRIO = 8,
    localparam int N_SRC = N_LINE + 2,
    localparam int SW    = IDX_W,
    localparam int PADW  = 1 << SW
) (
    input  logic [N_SRC-1:0]        usable,
    input  logic [N_PRIO*ENT_W-1:0] tab,
    input  logic                    paired,
    output logic                    found,
    output logic [SW-1:0]           best
);

    localparam logic [SW-1:0] PAIR_ORD [4] = '{
        SW'(0), SW'(1), SW'(N_LINE), SW'(N_LINE + 1)
    };

    logic [PADW-1:0] upad;

    // Indices beyond the last candidate read as unusable.
    always_comb begin
        upad = '0;
        upad[N_SRC-1:0] = usable;
    end

    // Scan from lowest rank upward so the highest-ranked hit is kept last.
    always_comb begin
        found = 1'b0;
        best  = SW'(N_LINE);
        if (paired) begin
            for (int i = 3; i >= 0; i--) begin
                if (upad[PAIR_ORD[i]]) begin
                    found = 1'b1;
                    best  = PAIR_ORD[i];
                end
            end
        end else begin
            for (int i = N_PRIO - 1; i >= 0; i--) begin
                if (tab[i*ENT_W + SW] && upad[tab[i*ENT_W +: SW]]) begin
                    found = 1'b1;
                    best  = tab[i*ENT_W +: SW];
                end
            end
        end
    end

endmodule

// File: rtl/tsel_top.sv
module tsel_top
    import tsel_pkg::*;
#(
    parameter int N_LINE = 16,
    parameter int N_PRIO = 8,
    parameter int QW     = 8,
    localparam int N_SRC = N_LINE + 2,
    localparam int SW    = IDX_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    qual_tick,
    input  logic [N_LINE-1:0]       line_ok,
    input  logic [1:0]              osc_ok,
    input  logic                    paired_mode,
    input  logic [QW-1:0]           qual_limit,
    input  logic [N_PRIO*ENT_W-1:0] prio_tab,
    output logic [SW-1:0]           ref_sel,
    output logic                    ref_valid,
    output logic                    ref_switch
);

    localparam logic [SW-1:0] OSC_MAIN = SW'(N_LINE);

    logic [N_SRC-1:0] health;
    logic [N_SRC-1:0] usable;
    logic             found;
    logic [SW-1:0]    best;

    sel_state_t    state_q, state_d;
    logic [SW-1:0] sel_q, sel_d;
    logic          sw_q;

    assign health = {osc_ok, line_ok};

    // One qualifier per candidate source.
    for (genvar g = 0; g < N_SRC; g++) begin : g_qual
        tsel_qualifier #(.QW(QW)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (qual_tick),
            .ok    (health[g]),
            .limit (qual_limit),
            .qual  (usable[g])
        );
    end

    tsel_picker #(.N_LINE(N_LINE), .N_PRIO(N_PRIO)) u_pick (
        .usable (usable),
        .tab    (prio_tab),
        .paired (paired_mode),
        .found  (found),
        .best   (best)
    );

    // Next-state logic: ACQUIRE, HANDOVER, LOSE, HOLD.
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        unique case (state_q)
            ST_FREE: begin
                if (found) begin
                    state_d = ST_LOCKED;
                    sel_d   = best;
                end else begin
                    sel_d   = OSC_MAIN;
                end
            end
            ST_LOCKED: begin
                if (!found) begin
                    state_d = ST_FREE;
                    sel_d   = OSC_MAIN;
                end else if (best != sel_q) begin
                    sel_d   = best;
                end
            end
            default: begin
                state_d = ST_FREE;
                sel_d   = OSC_MAIN;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            sel_q   <= OSC_MAIN;
            sw_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
            sw_q    <= (sel_d != sel_q);
        end
    end

    // Outputs.
    always_comb begin
        ref_sel    = sel_q;
        ref_valid  = (state_q == ST_LOCKED);
        ref_switch = sw_q;
    end

endmodule

// File: rtl/tsel_top_chk.sv
module tsel_top_chk #(
    parameter int N_LINE = 16,
    parameter int SW     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_LINE-1:0] line_ok,
    input logic [1:0]        osc_ok,
    input logic              paired_mode,
    input logic [SW-1:0]     ref_sel,
    input logic              ref_valid,
    input logic              ref_switch
);

    localparam int N_SRC = N_LINE + 2;
    localparam int PADW  = 1 << SW;

    logic [PADW-1:0] hpad;
    always_comb begin
        hpad = '0;
        hpad[N_SRC-1:0] = {osc_ok, line_ok};
    end

    // R1: index always names a real candidate
    a_r1_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        ref_sel < SW'(N_SRC));

    // R6: invalid means parked on the main oscillator
    a_r6_fallback_main: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_valid |-> (ref_sel == SW'(N_LINE)));

    // R7: pulse exactly when the index changes
    a_r7_pulse_matches_change: assert property (@(posedge clk) disable iff (!rst_n)
        ref_switch == (ref_sel != $past(ref_sel)));

    // R4: a failed active source is left on the next edge
    a_r4_leave_failed: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && !hpad[ref_sel]) |=> (ref_sel != $past(ref_sel) || !ref_valid));

    // R9 / R10: paired mode selects only the four fixed candidates
    a_r9_paired_set: assert property (@(posedge clk) disable iff (!rst_n)
        $past(paired_mode) |-> (ref_sel == SW'(0) || ref_sel == SW'(1) ||
                                ref_sel == SW'(N_LINE) || ref_sel == SW'(N_LINE + 1)));

endmodule

bind tsel_top tsel_top_chk #(.N_LINE(N_LINE), .SW(SW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_ok     (line_ok),
    .osc_ok      (osc_ok),
    .paired_mode (paired_mode),
    .ref_sel     (ref_sel),
    .ref_valid   (ref_valid),
    .ref_switch  (ref_switch)
);

// File: tb/tsel_top_test.sv
module tsel_top_test;

    localparam int N_LINE = 16;
    localparam int N_PRIO = 8;
    localparam int QW     = 8;
    localparam int MAINO  = N_LINE;
    localparam int STBYO  = N_LINE + 1;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 qual_tick;
    logic [N_LINE-1:0]    line_ok;
    logic [1:0]           osc_ok;
    logic                 paired_mode;
    logic [QW-1:0]        qual_limit;
    logic [N_PRIO*6-1:0]  prio_tab;
    logic [4:0]           ref_sel;
    logic                 ref_valid;
    logic                 ref_switch;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tsel_top #(.N_LINE(N_LINE), .N_PRIO(N_PRIO), .QW(QW)) uut (
        .clk, .rst_n, .qual_tick, .line_ok, .osc_ok, .paired_mode,
        .qual_limit, .prio_tab, .ref_sel, .ref_valid, .ref_switch
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect3(input string tag, input int s, input int v, input int p);
        check({tag, " sel"},    int'(ref_sel),    s);
        check({tag, " valid"},  int'(ref_valid),  v);
        check({tag, " switch"}, int'(ref_switch), p);
    endtask

    task automatic set_entry(input int k, input bit en, input int idx);
        prio_tab[k*6 +: 6] = {en, 5'(idx)};
    endtask

    task automatic do_reset(input int lim);
        @(negedge clk);
        rst_n       = 1'b0;
        qual_tick   = 1'b1;
        line_ok     = '0;
        osc_ok      = '0;
        paired_mode = 1'b0;
        qual_limit  = QW'(lim);
        prio_tab    = '0;
        step(2);
        rst_n = 1'b1;
    endtask

    // R11 reset values
    task automatic t_reset();
        do_reset(3);
        expect3("R11 reset", MAINO, 0, 0);
    endtask

    // R2, R3, R7, R4, R5: qualify, failover, revert
    task automatic t_table_failover();
        do_reset(3);
        set_entry(0, 1'b1, 5);
        set_entry(1, 1'b1, 2);
        set_entry(2, 1'b1, MAINO);
        line_ok[5] = 1'b1;
        line_ok[2] = 1'b1;
        osc_ok[0]  = 1'b1;
        step(3);
        expect3("R3 one tick short", MAINO, 0, 0);
        step(1);
        expect3("R2 R7 acquire top entry", 5, 1, 1);
        step(1);
        expect3("R7 pulse one cycle", 5, 1, 0);
        line_ok[5] = 1'b0;
        step(1);
        expect3("R4 failover next edge", 2, 1, 1);
        line_ok[5] = 1'b1;
        step(3);
        expect3("R5 not yet requalified", 2, 1, 0);
        step(1);
        expect3("R5 revert to better", 5, 1, 1);
    endtask

    // R3: only ticked cycles count
    task automatic t_tick_gating();
        do_reset(3);
        set_entry(0, 1'b1, 5);
        qual_tick  = 1'b0;
        line_ok[5] = 1'b1;
        step(10);
        expect3("R3 no ticks no qualify", MAINO, 0, 0);
        qual_tick = 1'b1;
        step(3);
        check("R3 ticked short sel", int'(ref_sel), MAINO);
        step(1);
        expect3("R3 ticked qualify", 5, 1, 1);
    endtask

    // R3: zero limit acts at once
    task automatic t_zero_limit();
        do_reset(0);
        set_entry(0, 1'b1, 5);
        line_ok[5] = 1'b1;
        step(1);
        expect3("R3 zero limit", 5, 1, 1);
    endtask

    // R8 skipped entries, R6 total loss
    task automatic t_skip_and_loss();
        do_reset(0);
        set_entry(0, 1'b0, 7);
        set_entry(1, 1'b1, 20);
        set_entry(2, 1'b1, 9);
        line_ok[7] = 1'b1;
        line_ok[9] = 1'b1;
        osc_ok     = 2'b11;
        step(2);
        check("R8 disabled and out-of-range skipped", int'(ref_sel), 9);
        check("R8 valid", int'(ref_valid), 1);
        set_entry(2, 1'b0, 9);
        step(1);
        expect3("R6 no usable entry", MAINO, 0, 1);
        step(1);
        expect3("R6 stays parked", MAINO, 0, 0);
    endtask

    // R9, R10: paired fixed order
    task automatic t_paired();
        do_reset(0);
        paired_mode = 1'b1;
        set_entry(0, 1'b1, 3);
        line_ok[3] = 1'b1;
        line_ok[0] = 1'b1;
        line_ok[1] = 1'b1;
        osc_ok     = 2'b11;
        step(1);
        expect3("R9 primary port0", 0, 1, 1);
        line_ok[0] = 1'b0;
        step(1);
        expect3("R9 partner port0", 1, 1, 1);
        line_ok[1] = 1'b0;
        step(1);
        expect3("R9 main oscillator", MAINO, 1, 1);
        osc_ok[0] = 1'b0;
        step(1);
        expect3("R9 standby oscillator", STBYO, 1, 1);
        osc_ok[1] = 1'b0;
        step(1);
        expect3("R10 R6 line3 not a candidate", MAINO, 0, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        t_reset();
        t_table_failover();
        t_tick_gating();
        t_zero_limit();
        t_skip_and_loss();
        t_paired();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule